// File: doc/BRIEF.md
# Three-Die Electronic Dice Roller

This block rolls three six-sided dice and shows each one on its own seven-segment digit. Holding a pushbutton makes the dice tumble through every one of their 216 joint faces, one step per clock, far faster than the eye can follow. Letting go freezes the dice on whatever combination was current. The unpredictable result comes from the exact release moment, not from any pseudo-random generator.

The raw button is asynchronous and bouncy. It is first resynchronised by two flip-flops. A debouncer then accepts a level change only once the synchronised input has differed from the accepted level for 2^DEB_BITS consecutive clocks. The debounced level is the roll enable. The dice form a cascade: the first die steps every enabled clock, and each later die steps when every die before it wraps from 6 to 1.

Top module: `dice_roller`

## Requirements
- R1: While reset (rst_n low, asynchronous) is asserted, all three die outputs read 1 and all three segment outputs show the pattern for 1.
- R2: Every die output always holds a value in the range 1 to 6.
- R3: On every clock with the roll enable active, die A advances by one, and 6 wraps to 1.
- R4: Die B advances only on a clock where die A wraps from 6 to 1. Die C advances only on a clock where both A and B wrap. Otherwise each holds.
- R5: Over 216 consecutive rolling clocks, all 216 combinations appear exactly once, and the dice then return to the starting combination.
- R6: While the debounced button is released, the dice hold their values indefinitely.
- R7: A button level change lasting fewer than 2^DEB_BITS clocks is ignored, and the dice do not move.
- R8: After a button press held steadily, the dice do not move for at least 2^DEB_BITS clocks. They start rolling no later than 2^DEB_BITS + 6 clocks after the press.
- R9: Segment outputs are active-high with bit 0 = a through bit 6 = g. The patterns are 1=7'h06, 2=7'h5B, 3=7'h4F, 4=7'h66, 5=7'h6D and 6=7'h7D.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_raw | input | 1 | Raw pushbutton, asynchronous, active-high |
| die_a | output | 3 | First die value, 1..6 |
| die_b | output | 3 | Second die value, 1..6 |
| die_c | output | 3 | Third die value, 1..6 |
| seg_a | output | 7 | Segment pattern for die A (bit0=a..bit6=g) |
| seg_b | output | 7 | Segment pattern for die B |
| seg_c | output | 7 | Segment pattern for die C |

## Verification
The hardest situation to reach from the ports is a full turn of the cascade, where die C wraps from 6 back to 1. Reaching it requires holding the debounced enable for more than 216 uninterrupted clocks. The bench therefore shrinks the debounce window through the parameter and holds the button past the acceptance point. It then follows the dice for 260 clocks, predicting each combination as the successor of the previous one and counting the distinct combinations seen. Short glitches below the window are applied first, to show that the dice stay at their reset faces.

// File: rtl/dice_pkg.sv
package dice_pkg;
    localparam int DIE_W    = 3;
    localparam int SEG_W    = 7;
    localparam int NUM_DICE = 3;
    localparam int FACES    = 6;
    typedef logic [DIE_W-1:0] die_t;
    typedef logic [SEG_W-1:0] seg_t;
    localparam die_t FACE_MIN = die_t'(1);
    localparam die_t FACE_MAX = die_t'(FACES);
endpackage

// File: rtl/btn_sync.sv
module btn_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [1:0] sr_d, sr_q;

    always_comb begin
        sr_d = {sr_q[0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign sync_out = sr_q[1];
endmodule

// File: rtl/btn_debounce.sv
module btn_debounce #(
    parameter int DEB_BITS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    output logic level_out
);
    typedef struct packed {
        logic [DEB_BITS-1:0] cnt;
        logic                lvl;
    } deb_s;

    deb_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (level_in == st_q.lvl) begin
            st_d.cnt = '0;
        end else if (&st_q.cnt) begin
            st_d.cnt = '0;
            st_d.lvl = level_in;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_out = st_q.lvl;
endmodule

// File: rtl/die_stage.sv
module die_stage
    import dice_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    output die_t value,
    output logic at_top
);
    die_t val_d, val_q;

    always_comb begin
        val_d = val_q;
        if (val_q < FACE_MIN || val_q > FACE_MAX) begin
            val_d = FACE_MIN;
        end else if (step) begin
            val_d = (val_q == FACE_MAX) ? FACE_MIN : val_q + die_t'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= FACE_MIN;
        else        val_q <= val_d;
    end

    assign value  = val_q;
    assign at_top = (val_q == FACE_MAX);
endmodule

// File: rtl/seg_encode.sv
module seg_encode
    import dice_pkg::*;
(
    input  die_t face,
    output seg_t seg
);
    always_comb begin
        case (face)
            3'd1:    seg = 7'h06;
            3'd2:    seg = 7'h5B;
            3'd3:    seg = 7'h4F;
            3'd4:    seg = 7'h66;
            3'd5:    seg = 7'h6D;
            3'd6:    seg = 7'h7D;
            default: seg = 7'h40;
        endcase
    end
endmodule

// File: rtl/dice_roller.sv
module dice_roller
    import dice_pkg::*;
#(
    parameter int DEB_BITS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       btn_raw,
    output logic [2:0] die_a,
    output logic [2:0] die_b,
    output logic [2:0] die_c,
    output logic [6:0] seg_a,
    output logic [6:0] seg_b,
    output logic [6:0] seg_c
);
    logic btn_sync_lvl;
    logic roll_en;
    die_t face   [NUM_DICE];
    seg_t pat    [NUM_DICE];
    logic top    [NUM_DICE];
    logic step   [NUM_DICE];

    btn_sync i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (btn_raw),
        .sync_out (btn_sync_lvl)
    );

    btn_debounce #(.DEB_BITS(DEB_BITS)) i_deb (
        .clk       (clk),
        .rst_n     (rst_n),
        .level_in  (btn_sync_lvl),
        .level_out (roll_en)
    );

    for (genvar g = 0; g < NUM_DICE; g++) begin : g_die
        if (g == 0) begin : g_first
            assign step[g] = roll_en;
        end else begin : g_next
            assign step[g] = step[g-1] & top[g-1];
        end

        die_stage i_die (
            .clk    (clk),
            .rst_n  (rst_n),
            .step   (step[g]),
            .value  (face[g]),
            .at_top (top[g])
        );

        seg_encode i_seg (
            .face (face[g]),
            .seg  (pat[g])
        );
    end

    assign die_a = face[0];
    assign die_b = face[1];
    assign die_c = face[2];
    assign seg_a = pat[0];
    assign seg_b = pat[1];
    assign seg_c = pat[2];
endmodule

// File: rtl/dice_roller_chk.sv
module dice_roller_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       en,
    input logic [2:0] da,
    input logic [2:0] db,
    input logic [2:0] dc,
    input logic [6:0] sa
);
    AST_FACE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (da >= 3'd1 && da <= 3'd6 && db >= 3'd1 && db <= 3'd6 && dc >= 3'd1 && dc <= 3'd6)); // R2
    AST_A_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && da == 3'd6) |=> (da == 3'd1)); // R3
    AST_A_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (en && da < 3'd6) |=> (da == $past(da) + 3'd1)); // R3
    AST_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (da != 3'd6) |=> $stable(db)); // R4
    AST_C_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (da != 3'd6 || db != 3'd6) |=> $stable(dc)); // R4
    AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!en) |=> ($stable(da) && $stable(db) && $stable(dc))); // R6
    AST_SEG_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (da == 3'd1) |-> (sa == 7'h06)); // R9
endmodule

bind dice_roller dice_roller_chk i_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (roll_en),
    .da    (die_a),
    .db    (die_b),
    .dc    (die_c),
    .sa    (seg_a)
);

// File: tb/test_dice_roller.sv
module test_dice_roller;
    localparam int DEB = 4;
    localparam int WIN = 1 << DEB;
    localparam logic [6:0] SEG_TBL [0:5] = '{7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic btn = 1'b0;
    logic [2:0] die_a, die_b, die_c;
    logic [6:0] seg_a, seg_b, seg_c;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    dice_roller #(.DEB_BITS(DEB)) i_dice_roller (
        .clk(clk), .rst_n(rst_n), .btn_raw(btn),
        .die_a(die_a), .die_b(die_b), .die_c(die_c),
        .seg_a(seg_a), .seg_b(seg_b), .seg_c(seg_c)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int comb_idx();
        return (int'(die_a) - 1) + 6 * (int'(die_b) - 1) + 36 * (int'(die_c) - 1);
    endfunction

    task automatic chk_segs(input string req);
        if (die_a >= 1 && die_a <= 6) chk(seg_a == SEG_TBL[die_a-1], req, seg_a, SEG_TBL[die_a-1]);
        if (die_b >= 1 && die_b <= 6) chk(seg_b == SEG_TBL[die_b-1], req, seg_b, SEG_TBL[die_b-1]);
        if (die_c >= 1 && die_c <= 6) chk(seg_c == SEG_TBL[die_c-1], req, seg_c, SEG_TBL[die_c-1]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int prev, start, seen;
        bit visited [0:215];
        bit started;
        int snap;

        repeat (3) @(negedge clk);
        // R1 reset state
        chk(comb_idx() == 0, "R1", comb_idx(), 0);
        chk(seg_a == 7'h06 && seg_b == 7'h06 && seg_c == 7'h06, "R1", seg_a, 7'h06);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        chk(comb_idx() == 0, "R6", comb_idx(), 0);

        // R7 short glitch ignored
        btn = 1'b1;
        repeat (WIN / 2) @(negedge clk);
        btn = 1'b0;
        repeat (3 * WIN) @(negedge clk);
        chk(comb_idx() == 0, "R7", comb_idx(), 0);

        // R8 press latency
        btn = 1'b1;
        repeat (WIN) @(negedge clk);
        chk(comb_idx() == 0, "R8", comb_idx(), 0);
        started = 0;
        for (int k = 0; k < 6 && !started; k++) begin
            @(negedge clk);
            if (comb_idx() != 0) started = 1;
        end
        chk(started, "R8", started, 1);

        // R3 R4 R5 R9 rolling through the cascade
        for (int k = 0; k < 216; k++) visited[k] = 0;
        prev = comb_idx();
        start = prev;
        seen = 0;
        for (int k = 1; k <= 260; k++) begin
            int exp_i, ea, eb, ec;
            @(negedge clk);
            exp_i = (prev + 1) % 216;
            ea = exp_i % 6 + 1;
            eb = (exp_i / 6) % 6 + 1;
            ec = exp_i / 36 + 1;
            chk(die_a == ea, "R3", die_a, ea);
            chk(die_b == eb, "R4", die_b, eb);
            chk(die_c == ec, "R4", die_c, ec);
            chk_segs("R9");
            if (k <= 216 && comb_idx() >= 0 && comb_idx() < 216 && !visited[comb_idx()]) begin
                visited[comb_idx()] = 1;
                seen++;
            end
            if (k == 216) begin
                chk(comb_idx() == start, "R5", comb_idx(), start);
                chk(seen == 216, "R5", seen, 216);
            end
            prev = comb_idx();
        end

        // R6 freeze after release
        btn = 1'b0;
        repeat (WIN + 8) @(negedge clk);
        snap = comb_idx();
        repeat (50) @(negedge clk);
        chk(comb_idx() == snap, "R6", comb_idx(), snap);
        chk_segs("R9");

        // R1 asynchronous reset mid-run
        rst_n = 1'b0;
        #1;
        chk(comb_idx() == 0, "R1", comb_idx(), 0);
        chk(seg_c == 7'h06, "R1", seg_c, 7'h06);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule